// File: doc/BRIEF.md
# Fuse Security and Signature Controller

This block sits between a simple programming command port and the configuration fuse pattern of a programmable logic array. Each command arrives as a 3-bit operation code, an address and a write data word, qualified by a one-cycle strobe. The block decodes it, applies the security rules, updates its storage and answers with either a done pulse or an access-denied pulse, together with read data.

A single security bit protects the fuse pattern. While it is set, pattern verify reads and preload of the macrocell registers are refused. A separate 64-bit user signature of eight bytes stays open for both reading and writing whatever the security state. The security bit comes into force on the command that sets it, and only a full erase clears it. That erase also wipes the pattern in the same step.

Top module: `fuse_guard_ctrl`

## Requirements
- R1: After reset the security bit is clear, the preload bank, every pattern word and every signature byte read as zero, and rsp_done, rsp_denied and rsp_rdata are zero.
- R2: A permitted command raises rsp_done for exactly the one cycle after the strobe cycle. A cycle without a strobe is followed by a cycle with rsp_done and rsp_denied both low.
- R3: Op 2 (program) stores cmd_wdata into the pattern word selected by cmd_addr, and it is permitted even while secured. Op 1 (verify) returns that word.
- R4: Op 6 (secure) sets the security bit at once: a verify or preload in the very next cycle's command is already refused, and the bit stays set until an erase.
- R5: Op 3 (preload) loads cmd_wdata into the register bank and op 0 (register read) returns the bank. Op 0 is always permitted, and a preload refused under security leaves the bank unchanged.
- R6: A refused command raises rsp_denied for one cycle with rsp_rdata zero and no rsp_done, and it changes no state.
- R7: Op 4 (signature read) returns the signature byte indexed by cmd_addr[2:0] in rsp_rdata[7:0], with or without security.
- R8: Op 5 (signature write) stores cmd_wdata[7:0] into the byte indexed by cmd_addr[2:0], with or without security.
- R9: Op 7 (erase) clears every pattern word and the security bit in one command, and it keeps the signature and the preload bank.
- R10: Permitted commands that return no data (ops 2, 3, 5, 6, 7) give rsp_rdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Operation code |
| cmd_addr | input | ADDR_W | Pattern word address; bits [2:0] are the signature byte index |
| cmd_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| rsp_done | output | 1 | Command accepted and completed |
| rsp_denied | output | 1 | Command refused by the security rule |

## Verification
On every cycle the assertions check several things: the gating of verify and preload by the security bit, the one-cycle done and deny responses, zero data on a refusal, the stickiness of the security bit until an erase, and the constant availability of the signature. Only the bench's scenarios can show the data itself. That covers the pattern and signature contents read back after writes, the back-to-back secure-then-verify case, and the bank and signature that survive a refused preload and an erase. Those cases are compared against a separate model of the storage.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    OP_REGRD   = 3'd0,
    OP_VERIFY  = 3'd1,
    OP_PROG    = 3'd2,
    OP_PRELOAD = 3'd3,
    OP_SIGRD   = 3'd4,
    OP_SIGWR   = 3'd5,
    OP_SECURE  = 3'd6,
    OP_ERASE   = 3'd7
  } fsg_op_e;

  // Security rule: only verify and preload are locked out
  function automatic logic fsg_permitted(input fsg_op_e op, input logic secured);
    return !(secured && (op == OP_VERIFY || op == OP_PRELOAD));
  endfunction

  function automatic logic fsg_returns_data(input fsg_op_e op);
    return (op == OP_REGRD) || (op == OP_VERIFY) || (op == OP_SIGRD);
  endfunction

endpackage

// File: rtl/fsg_decode.sv
module fsg_decode
  import fsg_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       secured,
  output logic       accept,
  output logic       deny,
  output logic       do_prog,
  output logic       do_preload,
  output logic       do_sigwr,
  output logic       do_secure,
  output logic       do_erase,
  output logic       do_read
);
  fsg_op_e op;
  logic    ok;

  always_comb begin
    op         = fsg_op_e'(cmd_op);
    ok         = fsg_permitted(op, secured);
    accept     = cmd_valid && ok;
    deny       = cmd_valid && !ok;
    do_prog    = accept && (op == OP_PROG);
    do_preload = accept && (op == OP_PRELOAD);
    do_sigwr   = accept && (op == OP_SIGWR);
    do_secure  = accept && (op == OP_SECURE);
    do_erase   = accept && (op == OP_ERASE);
    do_read    = accept && fsg_returns_data(op);
  end
endmodule

// File: rtl/fsg_pattern_store.sv
module fsg_pattern_store #(
  parameter int WORDS  = 32,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              erase,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n || erase) begin
        mem_q[w] <= '0;
      end else if (wr_en && (addr == AW'(w))) begin
        mem_q[w] <= wdata;
      end
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/fsg_sig_store.sv
module fsg_sig_store #(
  parameter int BYTES = 8,
  parameter int IW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] byte_q [BYTES];

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        byte_q[b] <= '0;
      end else if (wr_en && (idx == IW'(b))) begin
        byte_q[b] <= wdata;
      end
    end
  end

  assign rdata = byte_q[idx];
endmodule

// File: rtl/fuse_guard_ctrl.sv
module fuse_guard_ctrl
  import fsg_pkg::*;
#(
  parameter int WORDS     = 32,
  parameter int DATA_W    = 8,
  parameter int SIG_BYTES = 8,
  parameter int ADDR_W    = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              rsp_denied
);
  localparam int SIG_IW = $clog2(SIG_BYTES);

  // Named internal events, visible to the bound checker
  logic              secure_q;
  logic [DATA_W-1:0] preload_q;
  logic              evt_accept, evt_deny;
  logic              evt_prog, evt_preload, evt_sigwr, evt_secure, evt_erase, evt_read;
  logic [DATA_W-1:0] pat_rd;
  logic [7:0]        sig_rd;
  logic [DATA_W-1:0] read_mux;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q, denied_q;

  fsg_decode dec_i (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .secured    (secure_q),
    .accept     (evt_accept),
    .deny       (evt_deny),
    .do_prog    (evt_prog),
    .do_preload (evt_preload),
    .do_sigwr   (evt_sigwr),
    .do_secure  (evt_secure),
    .do_erase   (evt_erase),
    .do_read    (evt_read)
  );

  fsg_pattern_store #(.WORDS(WORDS), .DATA_W(DATA_W), .AW(ADDR_W)) pat_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (evt_prog),
    .erase (evt_erase),
    .addr  (cmd_addr),
    .wdata (cmd_wdata),
    .rdata (pat_rd)
  );

  fsg_sig_store #(.BYTES(SIG_BYTES), .IW(SIG_IW)) sig_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (evt_sigwr),
    .idx   (cmd_addr[SIG_IW-1:0]),
    .wdata (cmd_wdata[7:0]),
    .rdata (sig_rd)
  );

  always_comb begin
    read_mux = '0;
    if (evt_read) begin
      unique case (fsg_op_e'(cmd_op))
        OP_REGRD:  read_mux = preload_q;
        OP_VERIFY: read_mux = pat_rd;
        OP_SIGRD:  read_mux = DATA_W'(sig_rd);
        default:   read_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      secure_q  <= 1'b0;
      preload_q <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
      denied_q  <= 1'b0;
    end else begin
      done_q   <= evt_accept;
      denied_q <= evt_deny;
      rdata_q  <= read_mux;
      if (evt_secure) begin
        secure_q <= 1'b1;
      end else if (evt_erase) begin
        secure_q <= 1'b0;
      end
      if (evt_preload) begin
        preload_q <= cmd_wdata;
      end
    end
  end

  assign rsp_rdata  = rdata_q;
  assign rsp_done   = done_q;
  assign rsp_denied = denied_q;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_done,
  input logic              rsp_denied,
  input logic              secure_q,
  input logic              evt_erase,
  input logic              evt_deny,
  input logic [DATA_W-1:0] preload_q
);
  a_r2_done_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !secure_q |=> rsp_done && !rsp_denied);

  a_r2_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_done && !rsp_denied);

  a_r4_secured_gate: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && secure_q && (cmd_op == 3'd1 || cmd_op == 3'd3) |=> rsp_denied && !rsp_done);

  a_r4_secure_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    secure_q && !evt_erase |=> secure_q);

  a_r6_deny_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_denied |-> rsp_rdata == '0);

  a_r6_deny_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    evt_deny |=> $stable(secure_q) && $stable(preload_q));

  a_r7_sig_always_open: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 3'd4 |=> rsp_done);

  a_r9_erase_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    evt_erase |=> !secure_q);

  always @(negedge clk) begin
    if (rst_n) begin
      a_r6_exclusive: assert (!(rsp_done && rsp_denied));
    end
  end
endmodule

bind fuse_guard_ctrl fsg_checker #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .rsp_rdata  (rsp_rdata),
  .rsp_done   (rsp_done),
  .rsp_denied (rsp_denied),
  .secure_q   (secure_q),
  .evt_erase  (evt_erase),
  .evt_deny   (evt_deny),
  .preload_q  (preload_q)
);

// File: tb/fuse_guard_ctrl_tb_top.sv
`timescale 1ns/1ps
module fuse_guard_ctrl_tb_top;
  localparam int WORDS  = 32;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cmd_valid = 1'b0;
  logic [2:0]        cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic [DATA_W-1:0] rsp_rdata;
  logic              rsp_done, rsp_denied;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model of the storage
  logic [7:0] m_pat [WORDS];
  logic [7:0] m_sig [8];
  logic [7:0] m_bank;
  bit         m_sec;

  always #2.5 clk = ~clk;

  fuse_guard_ctrl #(.WORDS(WORDS), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_denied(rsp_denied));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_permit(input int op, input bit sec);
    return !(sec && (op == 1 || op == 3));
  endfunction

  function automatic string data_req(input int op);
    case (op)
      0: return "R5";
      1: return "R3";
      4: return "R7";
      default: return "R10";
    endcase
  endfunction

  // Drive one command at the current falling edge; check the response one cycle later
  task automatic issue(input int op, input int addr, input int wd);
    bit ok = exp_permit(op, m_sec);
    int exp_d = 0;
    if (ok) begin
      case (op)
        0: exp_d = m_bank;
        1: exp_d = m_pat[addr];
        4: exp_d = m_sig[addr % 8];
        default: exp_d = 0;
      endcase
      case (op)
        2: m_pat[addr] = wd[7:0];
        3: m_bank = wd[7:0];
        5: m_sig[addr % 8] = wd[7:0];
        6: m_sec = 1;
        7: begin
          m_sec = 0;
          for (int i = 0; i < WORDS; i++) m_pat[i] = '0;
        end
        default: ;
      endcase
    end
    cmd_valid = 1'b1;
    cmd_op    = 3'(op);
    cmd_addr  = ADDR_W'(addr);
    cmd_wdata = DATA_W'(wd);
    @(negedge clk);
    check(rsp_done == ok && rsp_denied == !ok, ok ? "R2" : "R6",
          {rsp_done, rsp_denied}, {ok, !ok});
    check(rsp_rdata == DATA_W'(exp_d), ok ? data_req(op) : "R6", rsp_rdata, exp_d);
  endtask

  task automatic idle();
    cmd_valid = 1'b0;
    @(negedge clk);
    check(!rsp_done && !rsp_denied, "R2", {rsp_done, rsp_denied}, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a11));
    for (int i = 0; i < WORDS; i++) m_pat[i] = '0;
    for (int i = 0; i < 8; i++) m_sig[i] = '0;
    m_bank = '0;
    m_sec  = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports and through reads
    check(rsp_done == 0 && rsp_denied == 0 && rsp_rdata == 0, "R1",
          {rsp_done, rsp_denied, rsp_rdata}, 0);
    issue(0, 0, 0);
    for (int b = 0; b < 8; b++) issue(4, b, 0);
    issue(1, 31, 0);
    idle();
    // R3 program and verify, R5 preload, R8/R7 signature
    issue(2, 0, 8'h5a);
    issue(2, 31, 8'hc3);
    issue(1, 0, 0);
    issue(1, 31, 0);
    issue(3, 0, 8'h96);
    issue(0, 0, 0);
    for (int b = 0; b < 8; b++) issue(5, b, 8'h10 + b);
    for (int b = 7; b >= 0; b--) issue(4, b, 0);
    // R4: secure then verify in the very next cycle
    issue(6, 0, 0);
    issue(1, 0, 0);
    issue(3, 0, 8'h11);   // R6 refused preload
    issue(0, 0, 0);       // R5 bank kept
    issue(4, 3, 0);       // R7 while secured
    issue(5, 2, 8'hee);   // R8 while secured
    issue(4, 2, 0);
    issue(2, 5, 8'h77);   // R3 program while secured
    issue(6, 0, 0);
    issue(1, 5, 0);
    // R9: erase clears pattern and security, keeps signature and bank
    issue(7, 0, 0);
    issue(1, 5, 0);
    issue(1, 0, 0);
    issue(0, 0, 0);
    issue(4, 2, 0);
    idle();
    // Random mix
    for (int n = 0; n < 600; n++) begin
      int r = $urandom % 40;
      int op = (r == 0) ? 7 : (r == 1) ? 6 : (r % 6);
      if (($urandom % 8) == 0) idle();
      issue(op, $urandom % WORDS, $urandom % 256);
    end
    idle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule